// File: doc/BRIEF.md
# Fixed-Priority Shared Memory Access Scheduler

This block places one single-ported memory bank behind a set of independent hardware tasks. Each task has its own request, write-enable, address and write-data lines. In any cycle the block picks one requesting task by a fixed ranking and steers that task's lines onto the bank. It returns the bank's read data only to the chosen task. The pick is combinational, so a task that is selected finishes its one-cycle access in the same cycle in which it raised its request.

A task that is not picked keeps its request, address and write data steady. It is served in a later cycle in which no better-ranked task is asking. A one-cycle grant pulse tells it that its access went through.

Each task also has a relative deadline input that gives the number of cycles it may wait. A counter for each task measures how long that task's request has been outstanding. If the limit is passed, the block sets a sticky miss flag. A deadline of zero turns the check off, for tasks that can stall for any length of time.

Top module: `shared_bank_arbiter`

## Requirements
- R1: `grant` has at most one bit set in any cycle, and only for a task whose `req` bit is set; if any `req` bit is set, one grant bit is set.
- R2: When exactly one task requests, it is granted in that same cycle, and `mem_addr`, `mem_wdata` and `mem_we` carry that task's `t_addr`, `t_wdata` and `t_we` slices (slice i occupies bits i*W to i*W+W-1).
- R3: When several tasks request together, the task with the lowest index wins; index 0 ranks highest.
- R4: A task that keeps its request asserted after losing is granted in the first cycle in which no lower-indexed task requests.
- R5: `mem_en` is 1 exactly in cycles with a grant, and `mem_we` is 1 only when the granted task has its `t_we` bit set.
- R6: For a granted read (`t_we` bit 0), `rvalid` has only that task's bit set and that task's `t_rdata` slice equals `mem_rdata` in the same cycle; every other task's `rvalid` bit is 0 and its `t_rdata` slice is all zeros.
- R7: With a nonzero deadline D on a task, a request counts as late when it has not been granted in its first D cycles, the first cycle being the one in which `req` rises. The task's `miss` bit is 1 from the clock edge that ends the D-th ungranted cycle. D = 1 therefore tolerates no waiting, and D = 2 tolerates exactly one lost cycle.
- R8: A deadline of 0 means the task's `miss` bit never sets, however long the task waits.
- R9: Once set, a `miss` bit stays 1 until reset.
- R10: After reset, all `miss` bits are 0. With no requests, `grant`, `rvalid`, `mem_en` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | N_TASKS | Per-task access request, held until granted |
| t_we | input | N_TASKS | Per-task write select (1 write, 0 read) |
| t_addr | input | N_TASKS*ADDR_W | Per-task bank address slices |
| t_wdata | input | N_TASKS*DATA_W | Per-task write data slices |
| t_deadline | input | N_TASKS*CNT_W | Per-task relative deadline in cycles, 0 disables |
| grant | output | N_TASKS | One-hot grant, same cycle as request |
| rvalid | output | N_TASKS | Read data valid for the granted reader |
| t_rdata | output | N_TASKS*DATA_W | Per-task read data slices, zero when not served |
| miss | output | N_TASKS | Sticky deadline-miss flags |
| mem_en | output | 1 | Bank access enable |
| mem_we | output | 1 | Bank write enable |
| mem_addr | output | ADDR_W | Bank address |
| mem_wdata | output | DATA_W | Bank write data |
| mem_rdata | input | DATA_W | Bank read data, combinational from `mem_addr` |

## Verification
Grant, bank steering, `rvalid` and read data all arrive in the same cycle as the request. The bench drives each stimulus just after a falling edge and samples these outputs two nanoseconds later, before the next rising edge. The miss flags are registered, so each one is due at the rising edge that closes the D-th ungranted cycle. The bench checks them only after that edge, at the following falling edge. In a stall sequence it checks the flags cycle by cycle, so a flag that sets one cycle early or late shows up as a mismatch.

// File: rtl/sba_pkg.sv
package sba_pkg;

  // Saturating increment used by the per-task wait counters.
  function automatic logic [31:0] sba_sat_inc(input logic [31:0] v, input logic [31:0] lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction

endpackage

// File: rtl/sba_prio_pick.sv
module sba_prio_pick #(
  parameter int unsigned N_TASKS = 4
) (
  input  logic [N_TASKS-1:0] req,
  output logic [N_TASKS-1:0] gnt
);

  // Walk from the lowest rank upward so that the lowest index wins.
  always_comb begin
    gnt = '0;
    for (int i = N_TASKS - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sba_bank_mux.sv
module sba_bank_mux #(
  parameter int unsigned N_TASKS = 4,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned DATA_W  = 16
) (
  input  logic [N_TASKS-1:0]        gnt,
  input  logic [N_TASKS-1:0]        t_we,
  input  logic [N_TASKS*ADDR_W-1:0] t_addr,
  input  logic [N_TASKS*DATA_W-1:0] t_wdata,
  input  logic [DATA_W-1:0]         mem_rdata,
  output logic                      mem_en,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  output logic [N_TASKS-1:0]        rvalid,
  output logic [N_TASKS*DATA_W-1:0] t_rdata
);

  // Forward path: one-hot select of the granted task's lines.
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    for (int i = 0; i < N_TASKS; i++) begin
      if (gnt[i]) begin
        mem_en    = 1'b1;
        mem_we    = t_we[i];
        mem_addr  = t_addr[i*ADDR_W +: ADDR_W];
        mem_wdata = t_wdata[i*DATA_W +: DATA_W];
      end
    end
  end

  // Return path: read data reaches only the granted reader.
  for (genvar g = 0; g < N_TASKS; g++) begin : g_ret
    assign rvalid[g]                    = gnt[g] & ~t_we[g];
    assign t_rdata[g*DATA_W +: DATA_W]  = rvalid[g] ? mem_rdata : '0;
  end

endmodule

// File: rtl/sba_deadline_mon.sv
module sba_deadline_mon
  import sba_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             gnt,
  input  logic [CNT_W-1:0] limit,
  output logic             miss
);

  localparam logic [31:0] CNT_MAX = 32'((64'd1 << CNT_W) - 64'd1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             miss_q, miss_d;
  logic             cnt_en, miss_en;
  logic             waiting, late;

  // Next-state logic
  always_comb begin
    waiting = req & ~gnt;
    late    = waiting && (limit != '0) &&
              ({1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1} >= {1'b0, limit});
    cnt_d   = waiting ? CNT_W'(sba_sat_inc(32'(cnt_q), CNT_MAX)) : '0;
    cnt_en  = waiting | (cnt_q != '0);
    miss_d  = miss_q | late;
    miss_en = late;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (miss_en) miss_q <= miss_d;
    end
  end

  assign miss = miss_q;

  a_r9_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q |=> miss_q);

  a_r7_miss_needs_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_q) |-> $past(req && !gnt));

  a_r8_zero_limit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_q) |-> $past(limit != '0));

endmodule

// File: rtl/shared_bank_arbiter.sv
module shared_bank_arbiter #(
  parameter int unsigned N_TASKS = 4,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CNT_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_TASKS-1:0]        req,
  input  logic [N_TASKS-1:0]        t_we,
  input  logic [N_TASKS*ADDR_W-1:0] t_addr,
  input  logic [N_TASKS*DATA_W-1:0] t_wdata,
  input  logic [N_TASKS*CNT_W-1:0]  t_deadline,
  output logic [N_TASKS-1:0]        grant,
  output logic [N_TASKS-1:0]        rvalid,
  output logic [N_TASKS*DATA_W-1:0] t_rdata,
  output logic [N_TASKS-1:0]        miss,
  output logic                      mem_en,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic [DATA_W-1:0]         mem_rdata
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  sba_prio_pick #(.N_TASKS(N_TASKS)) u_pick (
    .req (req),
    .gnt (grant)
  );

  sba_bank_mux #(
    .N_TASKS(N_TASKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_mux (
    .gnt       (grant),
    .t_we      (t_we),
    .t_addr    (t_addr),
    .t_wdata   (t_wdata),
    .mem_rdata (mem_rdata),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rvalid    (rvalid),
    .t_rdata   (t_rdata)
  );

  for (genvar g = 0; g < N_TASKS; g++) begin : g_mon
    sba_deadline_mon #(.CNT_W(CNT_W)) u_mon (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .req   (req[g]),
      .gnt   (grant[g]),
      .limit (t_deadline[g*CNT_W +: CNT_W]),
      .miss  (miss[g])
    );

    // R3: no lower-indexed requester may be pending while task g holds the bus
    a_r3_rank_order: assert property (@(posedge clk) disable iff (!rst_sync_n)
      grant[g] |-> ((req & N_TASKS'((64'd1 << g) - 64'd1)) == '0));
  end

  a_r1_grant_onehot: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(grant));

  a_r1_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (grant & ~req) == '0);

  a_r4_work_conserving: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req != '0) |-> (grant != '0));

  a_r5_write_needs_enable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we |-> mem_en);

  a_r6_rvalid_only_granted: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rvalid & ~grant) == '0);

endmodule

// File: tb/shared_bank_arbiter_bench.sv
module shared_bank_arbiter_bench;

  localparam int unsigned N  = 4;
  localparam int unsigned AW = 10;
  localparam int unsigned DW = 16;
  localparam int unsigned CW = 8;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    req, t_we;
  logic [N*AW-1:0] t_addr;
  logic [N*DW-1:0] t_wdata;
  logic [N*CW-1:0] t_deadline;
  logic [N-1:0]    grant, rvalid, miss;
  logic [N*DW-1:0] t_rdata;
  logic            mem_en, mem_we;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wdata, mem_rdata;

  int n_chk  = 0;
  int n_fail = 0;

  shared_bank_arbiter #(.N_TASKS(N), .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_shared_bank_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .t_we(t_we), .t_addr(t_addr),
    .t_wdata(t_wdata), .t_deadline(t_deadline), .grant(grant), .rvalid(rvalid),
    .t_rdata(t_rdata), .miss(miss), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Bank model: combinational read, write on the clock edge.
  logic [DW-1:0] bmem [0:15];
  assign mem_rdata = bmem[mem_addr[3:0]];
  always @(posedge clk) if (mem_en && mem_we) bmem[mem_addr[3:0]] <= mem_wdata;

  // Stimulus table: upper nibble req (all reads), lower nibble expected grant.
  localparam logic [7:0] VEC [0:9] = '{8'h00, 8'h11, 8'h22, 8'h88, 8'hF1,
                                       8'hE2, 8'hC4, 8'hA2, 8'h62, 8'h44};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req   = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_dl(input int unsigned t, input int unsigned d);
    t_deadline[t*CW +: CW] = CW'(d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) bmem[i] = '0;
    rst_n      = 1'b0;
    req        = '0;
    t_we       = '0;
    t_deadline = '0;
    for (int i = 0; i < N; i++) begin
      t_addr[i*AW +: AW]  = AW'(i + 1);
      t_wdata[i*DW +: DW] = DW'(16'h1000 + i);
    end
    do_reset();

    // R10: reset state, idle
    #2;
    chk("R10 miss after reset", 32'(miss), 0);
    chk("R10 grant idle", 32'(grant), 0);
    chk("R10 mem_en idle", 32'(mem_en), 0);
    chk("R10 rvalid idle", 32'(rvalid), 0);

    // R1 R2 R3 R6: table walk, one vector per cycle
    for (int v = 0; v < 10; v++) begin
      logic [31:0] exp_addr;
      @(negedge clk);
      req = VEC[v][7:4];
      #2;
      exp_addr = 0;
      for (int i = 0; i < N; i++) if (VEC[v][i]) exp_addr = i + 1;
      chk("R3 table grant", 32'(grant), 32'(VEC[v][3:0]));
      chk("R2 table mem_addr", 32'(mem_addr), exp_addr);
      chk("R6 table rvalid", 32'(rvalid), 32'(VEC[v][3:0]));
      chk("R5 table mem_en", 32'(mem_en), 32'(VEC[v][3:0] != 0));
    end
    @(negedge clk);
    req = '0;

    // R2 R5: single writer, then same task reads back
    @(negedge clk);
    t_addr[2*AW +: AW]  = AW'(5);
    t_wdata[2*DW +: DW] = 16'hA5A5;
    t_we  = 4'b0100;
    req   = 4'b0100;
    #2;
    chk("R2 solo grant", 32'(grant), 32'h4);
    chk("R5 mem_we on write", 32'(mem_we), 1);
    chk("R2 mem_wdata", 32'(mem_wdata), 32'hA5A5);
    chk("R6 no rvalid on write", 32'(rvalid), 0);
    @(negedge clk);
    t_we = 4'b0000;
    #2;
    chk("R5 mem_we low on read", 32'(mem_we), 0);
    chk("R6 reader data", 32'(t_rdata[2*DW +: DW]), 32'hA5A5);
    chk("R6 rvalid reader only", 32'(rvalid), 32'h4);
    chk("R6 other slice zero", 32'(t_rdata[0*DW +: DW]), 0);
    @(negedge clk);
    req = '0;

    // R4: task 3 writes, loses to task 1, held, served next cycle
    @(negedge clk);
    t_addr[3*AW +: AW]  = AW'(9);
    t_wdata[3*DW +: DW] = 16'hBEEF;
    t_we = 4'b1000;
    req  = 4'b1010;
    #2;
    chk("R3 task1 beats task3", 32'(grant), 32'h2);
    chk("R5 loser write not issued", 32'(mem_we), 0);
    @(negedge clk);
    req = 4'b1000;
    #2;
    chk("R4 held request served", 32'(grant), 32'h8);
    chk("R4 held address", 32'(mem_addr), 9);
    @(negedge clk);
    t_we = '0;
    #2;
    chk("R4 held write landed", 32'(t_rdata[3*DW +: DW]), 32'hBEEF);
    @(negedge clk);
    req = '0;

    // R7: deadline 2 met after one lost cycle
    do_reset();
    set_dl(2, 2);
    @(negedge clk);
    req = 4'b0101;
    #2;
    chk("R7 d2 first cycle grant", 32'(grant), 32'h1);
    @(negedge clk);
    req = 4'b0100;
    #2;
    chk("R7 d2 served second cycle", 32'(grant), 32'h4);
    chk("R7 d2 no miss yet", 32'(miss), 0);
    @(negedge clk);
    req = '0;
    chk("R7 d2 met no miss", 32'(miss), 0);

    // R7 R8 R9: four tasks collide, deadlines t1=1, t2=2, t3=0
    do_reset();
    t_deadline = '0;
    set_dl(1, 1);
    set_dl(2, 2);
    @(negedge clk);
    req = 4'b1111;
    #2;
    chk("R3 collide grant", 32'(grant), 32'h1);
    @(negedge clk);
    req = 4'b1110;
    chk("R7 d1 missed after one cycle", 32'(miss), 32'h2);
    @(negedge clk);
    req = 4'b1100;
    chk("R7 d2 missed after two cycles", 32'(miss), 32'h6);
    @(negedge clk);
    req = 4'b1000;
    #2;
    chk("R4 last task served", 32'(grant), 32'h8);
    @(negedge clk);
    req = '0;
    repeat (4) @(negedge clk);
    chk("R8 R9 sticky and disabled", 32'(miss), 32'h6);
    do_reset();
    chk("R10 miss cleared", 32'(miss), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule